// File: doc/BRIEF.md
# Sixteen-Bit Timer/Counter with Prescaler and Buffered Byte Access

This block is a 16-bit up-counter for a microcontroller-style peripheral set. It counts either ticks of the internal instruction clock, which is the system clock divided by four, or rising edges on an external clock pin. External edges can pass through a two-flop synchronizer, or they can be taken straight from the pin with no synchronizer delay. A two-bit prescale field divides whichever source is selected by 1, 2, 4 or 8. A run enable gates counting. When the count wraps past its top value, a sticky overflow flag is set. A clear pulse from a compare unit's special-event trigger zeroes the count.

Software reaches the count over an 8-bit bus, one byte lane at a time. In 16-bit access mode, a read of the low byte copies the live high byte into a holding register, and a read of the high byte then returns that copy. In the same mode, a write to the high byte goes into the holding register only, and a write to the low byte loads all sixteen bits at once. Both 16-bit reads and 16-bit writes are therefore atomic. In 8-bit mode, each byte lane reads and writes the count directly.

The whole block runs on the system clock. In the unsynchronized mode the pin is sampled by a single register to find its edges, and the external clock is assumed to be slower than half the system clock in both external modes.

Top module: `tmr16_unit`

## Requirements
- R1: After a synchronous active-low reset, the count is 0x0000, the holding register is 0x00 and the overflow flag is 0.
- R2: With source select 0 and run enabled, the count rises by one every 4·D system cycles, where the prescale field gives D: 00→1, 01→2, 10→4, 11→8.
- R3: With source select 1 and bypass 0, each rising edge of the external pin, divided by D, advances the count. The count changes on the third clock edge after the pin rises.
- R4: With source select 1 and bypass 1, each divided rising edge advances the count on the first clock edge after the pin rises.
- R5: While run is disabled, the count holds its value.
- R6: A count step from 0xFFFF to 0x0000 sets the overflow flag. The flag stays set until a pulse on the flag-clear input.
- R7: The event-clear input zeroes the count on the next edge, and it overrides a bus write or an increment in the same cycle.
- R8: With 16-bit access on, a read at address 0 (low byte) copies the live high byte into the holding register. A read at address 1 (high byte) returns the holding register, even if the count has changed since.
- R9: With 16-bit access on, a write at address 1 changes only the holding register. A write at address 0 loads {holding register, data} into the count.
- R10: With 16-bit access off, address 0 and address 1 read and write the low and high count bytes directly.
- R11: A change of the prescale field, or any bus write that changes the count, restarts the divide chain. The next increment then needs a full 4·D cycles (or D edges).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Counting enable |
| clk_sel | input | 1 | 0: instruction clock, 1: external pin |
| sync_bypass | input | 1 | 1: take external edges without the synchronizer |
| presc_sel | input | 2 | Prescale field: divide by 1, 2, 4, 8 |
| rw16_en | input | 1 | 1: buffered 16-bit access |
| ext_clk | input | 1 | External count clock pin |
| evt_clr | input | 1 | Special-event clear pulse from the compare unit |
| ovf_clr | input | 1 | Clears the overflow flag |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 1 | 0: low byte, 1: high byte |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench separates the three clocking modes by latency. If the synchronizer bypass were wired backwards, the count would move on the wrong edge after an external rise. The bench restarts the divide chain partway through a prescale period: a design that did not clear the divide count on a write or on a prescale change would increment early. It clears the count between a low-byte read and a high-byte read, where a design without a holding register would return the live byte. It also checks that the flag is not set one step before the wrap, is set at the wrap, and stays set until cleared.

// File: rtl/tmr16_pkg.sv
// Shared constants and helpers for the 16-bit timer/counter.
// Assumes: the prescale field is narrow (a few bits), so its divider fits a small counter.
package tmr16_pkg;

    // Count source choices, matching the clk_sel pin encoding.
    typedef enum logic {
        SRC_INSTR = 1'b0,
        SRC_EXT   = 1'b1
    } tmr_src_e;

    // Byte lane addresses on the narrow bus.
    localparam logic ADDR_LO = 1'b0;
    localparam logic ADDR_HI = 1'b1;

endpackage

// File: rtl/tmr16_edge_detect.sv
// Finds rising edges of the external count clock. The edge comes either from a
// chain of SYNC_STAGES flops or, in bypass mode, from the raw pin against one
// sampled copy.
// Assumes: the external clock is slower than half the system clock, and
// SYNC_STAGES >= 2.
module tmr16_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic bypass_sync,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;
    logic                   raw_q;

    // Shift the pin through the synchronizer and keep delayed copies for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
            raw_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
            hist_q <= sync_q[SYNC_STAGES-1];
            raw_q  <= ext_in;
        end
    end

    // Pick the edge source for the selected external mode.
    always_comb begin
        if (bypass_sync) rise_o = ext_in & ~raw_q;
        else             rise_o = sync_q[SYNC_STAGES-1] & ~hist_q;
    end

    // R3 R4: an edge pulse lasts a single cycle in either mode.
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o && $stable(bypass_sync)) |=> !rise_o);

endmodule

// File: rtl/tmr16_prescaler.sv
// Divide chain: an instruction-clock divider (system clock / INSTR_DIV), a
// source select, and a 2^sel prescaler. It gives one increment strobe per
// prescaled tick. A restart, or a change of the prescale field, clears both
// dividers. While run is off, the dividers hold.
// Assumes: INSTR_DIV >= 2.
module tmr16_prescaler #(
    parameter int SEL_W     = 2,
    parameter int INSTR_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             use_ext,
    input  logic             ext_rise,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             inc_o
);

    localparam int QW  = $clog2(INSTR_DIV);
    localparam int PCW = (1 << SEL_W) - 1;

    logic [QW-1:0]    quarter_q;
    logic [PCW-1:0]   pre_q;
    logic [SEL_W-1:0] sel_q;
    logic [PCW-1:0]   pre_last;
    logic             base_tick;
    logic             sel_changed;
    logic             chain_clr;

    // Terminal prescale count for the selected ratio, and the tick from the chosen source.
    always_comb begin
        pre_last    = PCW'((32'd1 << sel) - 32'd1);
        base_tick   = use_ext ? ext_rise : (quarter_q == QW'(INSTR_DIV - 1));
        sel_changed = (sel != sel_q);
        chain_clr   = restart | sel_changed;
        inc_o       = run_en & ~chain_clr & base_tick & (pre_q == pre_last);
    end

    // Advance the two dividers while running; clear them on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quarter_q <= '0;
            pre_q     <= '0;
            sel_q     <= '0;
        end else begin
            sel_q <= sel;
            if (chain_clr) begin
                quarter_q <= '0;
                pre_q     <= '0;
            end else if (run_en) begin
                quarter_q <= (quarter_q == QW'(INSTR_DIV - 1)) ? '0 : quarter_q + 1'b1;
                if (base_tick) pre_q <= (pre_q == pre_last) ? '0 : pre_q + 1'b1;
            end
        end
    end

    // R11: a restart leaves the prescale count at zero.
    p_restart_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        chain_clr |=> (pre_q == '0));

    // R2: while the ratio is steady, the prescale count never passes its terminal value.
    p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_changed |-> (pre_q <= pre_last));

    // R5: with run off, the divide chain holds unless it is restarted.
    p_chain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !chain_clr) |=> ($stable(pre_q) && $stable(quarter_q)));

endmodule

// File: rtl/tmr16_count_core.sv
// The 16-bit count register, the sticky overflow flag and the byte-lane bus
// access through a holding register. Priority on the count: event clear, then
// a bus write to the count, then an increment.
// Assumes: the count is exactly two bus bytes wide.
module tmr16_count_core
    import tmr16_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             evt_clr,
    input  logic             ovf_clr,
    input  logic             rw16,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             ovf_o,
    output logic             cnt_wr_o
);

    localparam int CNT_W = 2 * BUS_W;

    logic [CNT_W-1:0] cnt_q;
    logic [BUS_W-1:0] hold_q;
    logic             wrap;
    logic             hold_wr;
    logic             hold_cap;

    // Decode the bus strobes into count load, holding-register write and capture.
    always_comb begin
        cnt_wr_o = bus_wr & ((bus_addr == ADDR_LO) | ~rw16);
        hold_wr  = bus_wr & rw16 & (bus_addr == ADDR_HI);
        hold_cap = bus_rd & rw16 & (bus_addr == ADDR_LO);
        wrap     = inc & (cnt_q == '1) & ~evt_clr & ~cnt_wr_o;
    end

    // Count register: clear, load from the bus, or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (evt_clr) begin
            cnt_q <= '0;
        end else if (cnt_wr_o) begin
            if (bus_addr == ADDR_LO)
                cnt_q <= rw16 ? {hold_q, bus_wdata} : {cnt_q[CNT_W-1:BUS_W], bus_wdata};
            else
                cnt_q <= {bus_wdata, cnt_q[BUS_W-1:0]};
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Holding register: written from the bus, or captures the high byte on a low read.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (hold_wr)  hold_q <= bus_wdata;
        else if (hold_cap) hold_q <= cnt_q[CNT_W-1:BUS_W];
    end

    // Overflow flag: set on wrap, cleared only by its clear input.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_o <= 1'b0;
        else if (wrap)    ovf_o <= 1'b1;
        else if (ovf_clr) ovf_o <= 1'b0;
    end

    // Read mux for the two byte lanes.
    assign bus_rdata = (bus_addr == ADDR_LO) ? cnt_q[BUS_W-1:0]
                     : (rw16 ? hold_q : cnt_q[CNT_W-1:BUS_W]);

    // R7: an event clear zeroes the count on the next edge.
    p_evt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr |=> (cnt_q == '0));

    // R6: a step from the top value raises the flag.
    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q == '1 && !evt_clr && !bus_wr) |=> ovf_o);

    // R6: the flag is sticky until it is cleared.
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr) |=> ovf_o);

    // R5: with no step, load or clear, the count holds.
    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !bus_wr && !evt_clr) |=> $stable(cnt_q));

    // R9: a buffered high write leaves the count alone.
    p_hold_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_wr && !inc && !evt_clr) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr16_unit.sv
// Top of the 16-bit timer/counter: external edge detection, the divide chain
// and the count core with byte-lane bus access.
// Assumes: all inputs are synchronous to clk, except ext_clk.
module tmr16_unit
    import tmr16_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int SEL_W       = 2,
    parameter int INSTR_DIV   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             clk_sel,
    input  logic             sync_bypass,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             rw16_en,
    input  logic             ext_clk,
    input  logic             evt_clr,
    input  logic             ovf_clr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             ovf_flag
);

    logic ext_rise;
    logic inc;
    logic cnt_wr;
    logic use_ext;

    assign use_ext = (tmr_src_e'(clk_sel) == SRC_EXT);

    tmr16_edge_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_in     (ext_clk),
        .bypass_sync(sync_bypass),
        .rise_o     (ext_rise)
    );

    tmr16_prescaler #(
        .SEL_W    (SEL_W),
        .INSTR_DIV(INSTR_DIV)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .use_ext (use_ext),
        .ext_rise(ext_rise),
        .sel     (presc_sel),
        .restart (cnt_wr),
        .inc_o   (inc)
    );

    tmr16_count_core #(
        .BUS_W(BUS_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .evt_clr  (evt_clr),
        .ovf_clr  (ovf_clr),
        .rw16     (rw16_en),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ovf_o    (ovf_flag),
        .cnt_wr_o (cnt_wr)
    );

    // R5: with run off, no increment reaches the count.
    p_no_step_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !inc);

endmodule

// File: tb/tmr16_unit_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected and observed values into queues,
// and a monitor pops and compares them on each falling edge.
module tmr16_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0, clk_sel = 1'b0, sync_bypass = 1'b0, rw16_en = 1'b1;
    logic [1:0] presc_sel = 2'b00;
    logic       ext_clk = 1'b0, evt_clr = 1'b0, ovf_clr = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ovf_flag;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int    exp_q[$];
    int    act_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    tmr16_unit u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .clk_sel(clk_sel),
        .sync_bypass(sync_bypass), .presc_sel(presc_sel), .rw16_en(rw16_en),
        .ext_clk(ext_clk), .evt_clr(evt_clr), .ovf_clr(ovf_clr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_flag(ovf_flag)
    );

    // Monitor: compare each observed value with its expected value.
    always @(negedge clk) begin
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            int    a_v;
            int    e_v;
            string t_v;
            a_v = act_q.pop_front();
            e_v = exp_q.pop_front();
            t_v = tag_q.pop_front();
            total++;
            if (a_v != e_v) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", t_v, a_v, e_v);
            end
        end
    end

    task automatic push(input string tag, input int act, input int exp);
        tag_q.push_back(tag);
        exp_q.push_back(exp);
        act_q.push_back(act);
    endtask

    task automatic bus_write(input logic addr, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic write16(input logic [15:0] v);
        bus_write(1'b1, v[15:8]);
        bus_write(1'b0, v[7:0]);
    endtask

    task automatic read16(output logic [15:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 1'b0;
        #1 v[7:0] = bus_rdata;
        @(negedge clk);
        bus_addr = 1'b1;
        #1 v[15:8] = bus_rdata;
        bus_rd = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic peek(input logic addr, output logic [7:0] v);
        bus_addr = addr;
        #1 v = bus_rdata;
    endtask

    task automatic run_for(input int edges);
        @(negedge clk);
        run_en = 1'b1;
        repeat (edges) @(posedge clk);
        @(negedge clk);
        run_en = 1'b0;
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0 || act_q.size() != 0) begin
            bad++;
            $display("FAIL scoreboard actual=%0d expected=0 pending items", act_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        peek(1'b0, b); push("R1 low byte", b, 0);
        peek(1'b1, b); push("R1 holding", b, 0);
        push("R1 overflow flag", ovf_flag, 0);

        // R2 timer mode at each ratio: 5 steps in 4*D*5+3 cycles
        for (int p = 0; p < 4; p++) begin
            presc_sel = 2'(p);
            write16(16'h0000);
            run_for(4 * (1 << p) * 5 + 3);
            read16(v); push($sformatf("R2 timer div%0d", 1 << p), v, 5);
        end

        // R5 hold while disabled
        repeat (30) @(negedge clk);
        read16(v); push("R5 hold while off", v, 5);

        // R11 restart by count write mid-period (div 8)
        presc_sel = 2'b11;
        write16(16'h0000);
        run_for(20);
        write16(16'h0000);
        run_for(12);
        read16(v); push("R11 write restarts chain", v, 0);
        run_for(20);
        read16(v); push("R11 full period after restart", v, 1);

        // R11 restart by prescale change
        write16(16'h0000);
        run_for(20);
        @(negedge clk); presc_sel = 2'b10;
        run_for(12);
        read16(v); push("R11 presc change restarts", v, 0);
        run_for(4);
        read16(v); push("R11 new ratio after change", v, 1);

        // R3 synchronized external counting, div 1 and div 2
        clk_sel = 1'b1; sync_bypass = 1'b0; presc_sel = 2'b00;
        write16(16'h0000);
        @(negedge clk); run_en = 1'b1;
        ext_pulses(6);
        @(negedge clk); run_en = 1'b0;
        read16(v); push("R3 sync edges div1", v, 6);
        presc_sel = 2'b01;
        write16(16'h0000);
        @(negedge clk); run_en = 1'b1;
        ext_pulses(6);
        @(negedge clk); run_en = 1'b0;
        read16(v); push("R3 sync edges div2", v, 3);

        // R3 synchronizer latency: the step lands on the third edge
        presc_sel = 2'b00;
        write16(16'h0000);
        @(negedge clk); run_en = 1'b1; ext_clk = 1'b1;
        @(negedge clk); peek(1'b0, b); push("R3 no step after 1 edge", b, 0);
        @(negedge clk);
        @(negedge clk); peek(1'b0, b); push("R3 step after 3 edges", b, 1);
        repeat (3) @(negedge clk); ext_clk = 1'b0;
        repeat (4) @(negedge clk); run_en = 1'b0;

        // R4 unsynchronized external counting and latency
        sync_bypass = 1'b1;
        write16(16'h0000);
        @(negedge clk); run_en = 1'b1;
        ext_pulses(6);
        @(negedge clk); run_en = 1'b0;
        read16(v); push("R4 bypass edges", v, 6);
        @(negedge clk); run_en = 1'b1; ext_clk = 1'b1;
        @(negedge clk); peek(1'b0, b); push("R4 step after 1 edge", b, 7);
        repeat (3) @(negedge clk); ext_clk = 1'b0;
        repeat (3) @(negedge clk); run_en = 1'b0;
        clk_sel = 1'b0; sync_bypass = 1'b0;

        // R6 overflow at the wrap, sticky until cleared
        presc_sel = 2'b00;
        write16(16'hFFFE);
        run_for(4);
        push("R6 no flag before wrap", ovf_flag, 0);
        read16(v); push("R6 count at top", v, 16'hFFFF);
        run_for(4);
        push("R6 flag set on wrap", ovf_flag, 1);
        read16(v); push("R6 count wrapped", v, 0);
        repeat (10) @(negedge clk);
        push("R6 flag sticky", ovf_flag, 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        push("R6 flag cleared", ovf_flag, 0);

        // R7 event clear overrides a simultaneous write
        write16(16'h3344);
        @(negedge clk);
        evt_clr = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h77;
        @(negedge clk);
        evt_clr = 1'b0; bus_wr = 1'b0;
        read16(v); push("R7 clear beats write", v, 0);

        // R8 buffered high byte survives a count change
        write16(16'h12FF);
        @(negedge clk); bus_rd = 1'b1; bus_addr = 1'b0;
        @(negedge clk); bus_rd = 1'b0; evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0;
        peek(1'b1, b); push("R8 buffered high byte", b, 8'h12);

        // R9 high write goes to holding only, low write loads both
        bus_write(1'b1, 8'hAB);
        @(negedge clk); rw16_en = 1'b0;
        peek(1'b1, b); push("R9 count high untouched", b, 0);
        @(negedge clk); rw16_en = 1'b1;
        bus_write(1'b0, 8'hCD);
        read16(v); push("R9 atomic load", v, 16'hABCD);

        // R10 direct byte access without buffering
        @(negedge clk); rw16_en = 1'b0;
        bus_write(1'b1, 8'h5A);
        @(negedge clk); peek(1'b1, b); push("R10 direct high write", b, 8'h5A);
        bus_write(1'b0, 8'h11);
        @(negedge clk); peek(1'b0, b); push("R10 direct low write", b, 8'h11);
        @(negedge clk); bus_rd = 1'b1; bus_addr = 1'b0;
        @(negedge clk); bus_rd = 1'b0; evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0;
        peek(1'b1, b); push("R10 live high read", b, 0);

        done = 1;
        finish_run();
    end

endmodule